// File: doc/BRIEF.md
# Instruction Cache Line Invalidate Unit

This unit carries out the instruction-cache block-invalidate operation on a small tag store. It is given a 32-bit instruction word and a one-cycle `start` strobe. It decodes the word and sends the two register-file read selects out. From the operand values that come back it forms an effective address. That address is presented for one cycle as a load-class access, so the translation and debug address-compare logic can examine it. In the same cycle the unit looks the address up in a 2-way set-associative tag array with 32-byte lines and 64 sets. A hitting line has its valid bit cleared. No architected register is written.

Translation and protection results come back during the lookup cycle. A data TLB-miss flag or a data-storage flag is raised as it would be for a load. A flagged access invalidates nothing. The cacheability attribute of the address has no effect on whether a line is dropped. One cycle after the lookup, a single-cycle `done` pulse reports the result. The same cycle carries the invalidated way mask and the exception flags. A write port lets the refill logic outside the unit install tags.

Top module: `icinv_unit`

## Requirements
- R1: The word is accepted only when `instr[31:26]` is 31 and `instr[10:1]` is 982. A `start` with any other word is ignored: `loadProbe` and `done` stay low.
- R2: Reserved bits `instr[25:21]` and `instr[0]` are not checked. A word with them non-zero runs as a normal invalidate.
- R3: `raSel` is `instr[20:16]` and `rbSel` is `instr[15:11]`. The effective address is `rbVal` plus a base. The base is 0 when the rA field is 0 and `raVal` otherwise. It appears on `eaOut` while `loadProbe` is high, in the cycle after the accepting edge.
- R4: The set index is `ea[10:5]` and the tag is `ea[31:11]`. Every way whose valid entry in that set holds the tag has its valid bit cleared. In the `done` cycle, bit w of `invWays` marks way w and `invSet` gives the set.
- R5: On a miss, `done` still pulses, `invWays` is 0 and no valid bit changes.
- R6: `attrCacheable` has no effect on invalidation.
- R7: `tlbMissExc` is raised with `done` when `dataReloc` was high at the accepting edge and `tlbHit` is low during the `loadProbe` cycle.
- R8: `dsExc` is raised with `done` when `userMode` and `dataReloc` were high at the accepting edge, and `tlbHit` and `zoneNoAccess` are both high during the `loadProbe` cycle.
- R9: When either exception is raised, no line is invalidated and `invWays` is 0.
- R10: `done` is a one-cycle pulse in the cycle after `loadProbe`. A `start` that arrives while `loadProbe` is high is ignored.
- R11: After reset all lines are invalid, and `done`, `loadProbe`, `invWays` and both exception flags are 0.
- R12: A `fillEn` edge writes `fillTag` into way `fillWay`, set `fillSet`, and marks it valid. An invalidate of the same line at the same edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction issue strobe |
| instr | input | 32 | Instruction word |
| raSel | output | 5 | Register-file select for the base operand |
| rbSel | output | 5 | Register-file select for the index operand |
| raVal | input | 32 | Base register value |
| rbVal | input | 32 | Index register value |
| userMode | input | 1 | Processor in user mode (sampled at accept) |
| dataReloc | input | 1 | Data relocation enabled (sampled at accept) |
| loadProbe | output | 1 | Load-class access presented for translation and debug compare |
| eaOut | output | 32 | Effective address of the access |
| tlbHit | input | 1 | Valid translation found (sampled during probe) |
| zoneNoAccess | input | 1 | Zone protection forbids access (sampled during probe) |
| attrCacheable | input | 1 | Cacheability attribute of the address (no effect) |
| fillEn | input | 1 | Tag install strobe |
| fillWay | input | 1 | Way to install into |
| fillSet | input | 6 | Set to install into |
| fillTag | input | 21 | Tag to install |
| invWays | output | 2 | Per-way invalidate mask, valid with done |
| invSet | output | 6 | Set of the invalidate, valid with done |
| done | output | 1 | Completion pulse |
| tlbMissExc | output | 1 | Data TLB-miss exception, with done |
| dsExc | output | 1 | Data-storage exception, with done |

## Verification
The embedded properties hold on every cycle. They cover the following: `done` is a single-cycle pulse that follows each probe; a hitting line's valid bit is gone after the invalidate edge; a miss or an exception yields an empty way mask; the two exception flags never coincide; and a cleared cacheable attribute does not suppress a hit. Some behaviour only the bench's scenarios can show, because it depends on the contents of the store. Examples are that a second invalidate of the same address then misses, that a line survives an excepted invalidate, that a fill colliding with an invalidate is lost, and that a line duplicated across both ways is dropped from both. Those scenarios also cover address formation with and without a base register, and the rejection of near-miss opcodes.

// File: rtl/icinv_pkg.sv
package icinv_pkg;
  localparam logic [5:0] PRIMARY_OP = 6'd31;
  localparam logic [9:0] EXT_OP     = 10'd982;

  typedef enum logic { ST_IDLE, ST_PROBE } phase_e;

  typedef struct packed {
    logic captureEa;
    logic probe;
    logic doInval;
  } ctrl_strobes_t;
endpackage

// File: rtl/icinv_ctrl.sv
module icinv_ctrl
  import icinv_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   instr,
  input  logic          userMode,
  input  logic          dataReloc,
  input  logic          tlbHit,
  input  logic          zoneNoAccess,
  output logic [4:0]    raSel,
  output logic [4:0]    rbSel,
  output logic          raIsZero,
  output ctrl_strobes_t ctrlS,
  output logic          done,
  output logic          tlbMissExc,
  output logic          dsExc
);
  phase_e phase;
  logic   decodeOk, accept, rsvdNonZero;
  logic   userQ, relocQ;
  logic   excTlb, excStorage;

  assign raSel       = instr[20:16];
  assign rbSel       = instr[15:11];
  assign raIsZero    = (raSel == 5'd0);
  assign decodeOk    = (instr[31:26] == PRIMARY_OP) && (instr[10:1] == EXT_OP);
  assign rsvdNonZero = |{instr[25:21], instr[0]};
  assign accept      = start && (phase == ST_IDLE) && decodeOk;

  // Access is classified as a load: translation miss first, then protection.
  assign excTlb     = relocQ && !tlbHit;
  assign excStorage = userQ && relocQ && tlbHit && zoneNoAccess;

  always_comb begin
    ctrlS.captureEa = accept;
    ctrlS.probe     = (phase == ST_PROBE);
    ctrlS.doInval   = (phase == ST_PROBE) && !excTlb && !excStorage;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= ST_IDLE;
      userQ      <= 1'b0;
      relocQ     <= 1'b0;
      done       <= 1'b0;
      tlbMissExc <= 1'b0;
      dsExc      <= 1'b0;
    end else begin
      done       <= (phase == ST_PROBE);
      tlbMissExc <= (phase == ST_PROBE) && excTlb;
      dsExc      <= (phase == ST_PROBE) && excStorage;
      if (accept) begin
        phase  <= ST_PROBE;
        userQ  <= userMode;
        relocQ <= dataReloc;
      end else if (phase == ST_PROBE) begin
        phase <= ST_IDLE;
      end
    end
  end

  p_bad_word_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !decodeOk && phase == ST_IDLE) |=> (phase == ST_IDLE));

  p_reserved_accepted_r2: assert property (@(posedge clk) disable iff (rst)
    (start && decodeOk && rsvdNonZero && phase == ST_IDLE) |=> (phase == ST_PROBE));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_probe_then_done_r10: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_PROBE) |=> (done && phase == ST_IDLE));
endmodule

// File: rtl/icinv_datapath.sv
module icinv_datapath
  import icinv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 2,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobes_t     ctrlS,
  input  logic              raIsZero,
  input  logic [ADDR_W-1:0] raVal,
  input  logic [ADDR_W-1:0] rbVal,
  input  logic              attrCacheable,
  input  logic              fillEn,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [IDX_W-1:0]  fillSet,
  input  logic [TAG_W-1:0]  fillTag,
  output logic [ADDR_W-1:0] eaOut,
  output logic [WAYS-1:0]   invWays,
  output logic [IDX_W-1:0]  invSet
);
  logic [ADDR_W-1:0] eaQ;
  logic [IDX_W-1:0]  setIdx;
  logic [TAG_W-1:0]  tagKey;
  logic [WAYS-1:0]   hitWays;

  assign setIdx = eaQ[OFF_W +: IDX_W];
  assign tagKey = eaQ[ADDR_W-1 -: TAG_W];
  assign eaOut  = eaQ;

  always_ff @(posedge clk) begin
    if (rst) eaQ <= '0;
    else if (ctrlS.captureEa) eaQ <= (raIsZero ? '0 : raVal) + rbVal;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tagMem [SETS];
    logic [SETS-1:0]  lineValid;
    logic             fillHere;

    assign fillHere   = fillEn && (fillWay == WAY_W'(w));
    assign hitWays[w] = lineValid[setIdx] && (tagMem[setIdx] == tagKey);

    always_ff @(posedge clk) begin
      if (fillHere) tagMem[fillSet] <= fillTag;
    end

    always_ff @(posedge clk) begin
      if (rst) lineValid <= '0;
      else begin
        if (fillHere) lineValid[fillSet] <= 1'b1;
        if (ctrlS.doInval && hitWays[w]) lineValid[setIdx] <= 1'b0;
      end
    end

    p_hit_line_cleared_r4: assert property (@(posedge clk) disable iff (rst)
      (ctrlS.doInval && hitWays[w]) |=> !lineValid[$past(setIdx)]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      invWays <= '0;
      invSet  <= '0;
    end else begin
      invWays <= ctrlS.doInval ? hitWays : '0;
      invSet  <= setIdx;
    end
  end

  p_miss_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrlS.probe && hitWays == '0) |=> (invWays == '0));

  p_attr_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrlS.doInval && |hitWays && !attrCacheable) |=> (|invWays));
endmodule

// File: rtl/icinv_unit.sv
module icinv_unit
  import icinv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 2,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       instr,
  output logic [4:0]        raSel,
  output logic [4:0]        rbSel,
  input  logic [ADDR_W-1:0] raVal,
  input  logic [ADDR_W-1:0] rbVal,
  input  logic              userMode,
  input  logic              dataReloc,
  output logic              loadProbe,
  output logic [ADDR_W-1:0] eaOut,
  input  logic              tlbHit,
  input  logic              zoneNoAccess,
  input  logic              attrCacheable,
  input  logic              fillEn,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [IDX_W-1:0]  fillSet,
  input  logic [TAG_W-1:0]  fillTag,
  output logic [WAYS-1:0]   invWays,
  output logic [IDX_W-1:0]  invSet,
  output logic              done,
  output logic              tlbMissExc,
  output logic              dsExc
);
  ctrl_strobes_t ctrlS;
  logic          raIsZero;

  icinv_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .instr(instr),
    .userMode(userMode), .dataReloc(dataReloc),
    .tlbHit(tlbHit), .zoneNoAccess(zoneNoAccess),
    .raSel(raSel), .rbSel(rbSel), .raIsZero(raIsZero),
    .ctrlS(ctrlS), .done(done), .tlbMissExc(tlbMissExc), .dsExc(dsExc)
  );

  icinv_datapath #(
    .ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LINE_BYTES)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrlS(ctrlS), .raIsZero(raIsZero),
    .raVal(raVal), .rbVal(rbVal), .attrCacheable(attrCacheable),
    .fillEn(fillEn), .fillWay(fillWay), .fillSet(fillSet), .fillTag(fillTag),
    .eaOut(eaOut), .invWays(invWays), .invSet(invSet)
  );

  assign loadProbe = ctrlS.probe;

  p_exc_blocks_inval_r9: assert property (@(posedge clk) disable iff (rst)
    (tlbMissExc || dsExc) |-> (invWays == '0));

  p_exc_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(tlbMissExc && dsExc));

  p_flags_need_done_r7: assert property (@(posedge clk) disable iff (rst)
    (tlbMissExc || dsExc || |invWays) |-> done);
endmodule

// File: tb/icinv_unit_test.sv
`timescale 1ns/1ps
module icinv_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [4:0]  raSel, rbSel;
  logic [31:0] raVal = '0, rbVal = '0;
  logic        userMode = 1'b0, dataReloc = 1'b0;
  logic        loadProbe;
  logic [31:0] eaOut;
  logic        tlbHit = 1'b1, zoneNoAccess = 1'b0, attrCacheable = 1'b1;
  logic        fillEn = 1'b0;
  logic [0:0]  fillWay = '0;
  logic [5:0]  fillSet = '0;
  logic [20:0] fillTag = '0;
  logic [1:0]  invWays;
  logic [5:0]  invSet;
  logic        done, tlbMissExc, dsExc;

  icinv_unit uut (
    .clk(clk), .rst(rst), .start(start), .instr(instr),
    .raSel(raSel), .rbSel(rbSel), .raVal(raVal), .rbVal(rbVal),
    .userMode(userMode), .dataReloc(dataReloc),
    .loadProbe(loadProbe), .eaOut(eaOut),
    .tlbHit(tlbHit), .zoneNoAccess(zoneNoAccess), .attrCacheable(attrCacheable),
    .fillEn(fillEn), .fillWay(fillWay), .fillSet(fillSet), .fillTag(fillTag),
    .invWays(invWays), .invSet(invSet), .done(done),
    .tlbMissExc(tlbMissExc), .dsExc(dsExc)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string curReq = "R11";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0]  setOf(input logic [31:0] a); return a[10:5];  endfunction
  function automatic logic [20:0] tagOf(input logic [31:0] a); return a[31:11]; endfunction

  // Behavioural reference model, advanced on each rising edge.
  bit          mValid [2][64];
  bit [20:0]   mTag   [2][64];
  bit          mBusy, mUser, mReloc;
  bit [31:0]   mEa;
  bit          expDone, expTlb, expDs, expProbe;
  bit [1:0]    expWays;
  bit [5:0]    expSet;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int w = 0; w < 2; w++) for (int s = 0; s < 64; s++) mValid[w][s] = 1'b0;
      mBusy = 0; expDone = 0; expTlb = 0; expDs = 0; expWays = 0; expProbe = 0;
    end else begin
      bit nd, nt, ns;
      bit [1:0] nw;
      bit [5:0] st;
      nd = 0; nt = 0; ns = 0; nw = 0; st = setOf(mEa);
      if (mBusy) begin
        nd = 1;
        nt = mReloc && !tlbHit;
        ns = mUser && mReloc && tlbHit && zoneNoAccess;
        if (!nt && !ns)
          for (int w = 0; w < 2; w++)
            if (mValid[w][st] && mTag[w][st] == tagOf(mEa)) nw[w] = 1'b1;
        mBusy = 0;
      end else if (start && instr[31:26] == 6'd31 && instr[10:1] == 10'd982) begin
        mEa    = ((instr[20:16] == 5'd0) ? 32'd0 : raVal) + rbVal;
        mUser  = userMode;
        mReloc = dataReloc;
        mBusy  = 1;
      end
      if (fillEn) begin
        mTag[fillWay][fillSet]   = fillTag;
        mValid[fillWay][fillSet] = 1'b1;
      end
      for (int w = 0; w < 2; w++) if (nw[w]) mValid[w][st] = 1'b0;
      expDone = nd; expTlb = nt; expDs = ns; expWays = nw; expSet = st;
      expProbe = mBusy;
    end
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      check(done == expDone, curReq, "done", done, expDone);
      check(loadProbe == expProbe, curReq, "loadProbe", loadProbe, expProbe);
      check(invWays == expWays, curReq, "invWays", invWays, expWays);
      check(tlbMissExc == expTlb, curReq, "tlbMissExc", tlbMissExc, expTlb);
      check(dsExc == expDs, curReq, "dsExc", dsExc, expDs);
      if (expProbe) check(eaOut == mEa, curReq, "eaOut", eaOut, mEa);
      if (expDone)  check(invSet == expSet, curReq, "invSet", invSet, expSet);
    end
  end

  function automatic logic [31:0] mkWord(input logic [4:0] ra, input logic [4:0] rb,
                                         input logic [5:0] rsv, input logic [9:0] xo);
    return {6'd31, rsv[5:1], ra, rb, xo, rsv[0]};
  endfunction

  task automatic fillLine(input bit way, input logic [31:0] a);
    @(negedge clk);
    fillEn = 1; fillWay = way; fillSet = setOf(a); fillTag = tagOf(a);
    @(negedge clk);
    fillEn = 0;
  endtask

  task automatic runOp(input logic [4:0] ra, input logic [4:0] rb,
                       input logic [31:0] a, input logic [31:0] b,
                       input bit usr, input bit rel, input bit th, input bit zn,
                       input bit cach, input logic [5:0] rsv, input logic [9:0] xo,
                       input int nStart);
    @(negedge clk);
    instr = mkWord(ra, rb, rsv, xo);
    raVal = a; rbVal = b; userMode = usr; dataReloc = rel;
    tlbHit = th; zoneNoAccess = zn; attrCacheable = cach; start = 1;
    #1;
    check(raSel == ra, "R3", "raSel", raSel, ra);
    check(rbSel == rb, "R3", "rbSel", rbSel, rb);
    repeat (nStart - 1) @(negedge clk);
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
  endtask

  localparam logic [31:0] ADDR_A = 32'h1234_5660;
  localparam logic [31:0] ADDR_B = 32'h0ABC_D660;
  localparam logic [31:0] ADDR_C = 32'h0000_8FE0;

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(done == 0 && loadProbe == 0 && invWays == 0 && tlbMissExc == 0 && dsExc == 0,
          "R11", "outputs in reset", {done, loadProbe, invWays, tlbMissExc, dsExc}, 0);
    rst = 0;
    @(negedge clk);
    curReq = "R11"; runOp(5'd0, 5'd4, 0, ADDR_A, 0, 0, 1, 0, 1, 6'd0, 10'd982, 1);

    curReq = "R12"; fillLine(0, ADDR_A); fillLine(1, ADDR_B);
    // R4: hit in way 0 with base zero (rA field 0)
    curReq = "R4";  runOp(5'd0, 5'd7, 32'hFFFF_FFFF, ADDR_A, 0, 0, 1, 0, 1, 6'd0, 10'd982, 1);
    // R5: same address now misses
    curReq = "R5";  runOp(5'd0, 5'd7, 0, ADDR_A, 0, 0, 1, 0, 1, 6'd0, 10'd982, 1);
    // R3: non-zero rA field adds base
    curReq = "R3";  runOp(5'd3, 5'd9, ADDR_B - 32'h40, 32'h40, 0, 0, 1, 0, 1, 6'd0, 10'd982, 1);

    fillLine(0, ADDR_C);
    // R7, R9: translation miss blocks invalidate, line survives
    curReq = "R7";  runOp(5'd1, 5'd2, ADDR_C, 0, 0, 1, 0, 0, 1, 6'd0, 10'd982, 1);
    // R8, R9: user-mode zone protection
    curReq = "R8";  runOp(5'd1, 5'd2, ADDR_C, 0, 1, 1, 1, 1, 1, 6'd0, 10'd982, 1);
    // R8: supervisor mode ignores zone protection and invalidates
    curReq = "R8";  runOp(5'd1, 5'd2, ADDR_C, 0, 0, 1, 1, 1, 1, 6'd0, 10'd982, 1);
    // R7: no relocation means no TLB exception
    fillLine(1, ADDR_C);
    curReq = "R7";  runOp(5'd0, 5'd2, 0, ADDR_C, 1, 0, 0, 1, 1, 6'd0, 10'd982, 1);

    // R6: non-cacheable attribute still invalidates
    fillLine(1, ADDR_A);
    curReq = "R6";  runOp(5'd0, 5'd6, 0, ADDR_A + 5, 0, 0, 1, 0, 0, 6'd0, 10'd982, 1);
    // R2: reserved bits set
    fillLine(0, ADDR_B);
    curReq = "R2";  runOp(5'd0, 5'd6, 0, ADDR_B, 0, 0, 1, 0, 1, 6'b101011, 10'd982, 1);
    // R1: wrong extended opcode ignored, line stays for next check
    fillLine(0, ADDR_A);
    curReq = "R1";  runOp(5'd0, 5'd6, 0, ADDR_A, 0, 0, 1, 0, 1, 6'd0, 10'd983, 1);
    curReq = "R1";
    @(negedge clk); instr = 32'h7C00_07AC ^ 32'h0400_0000; start = 1;
    @(negedge clk); start = 0; repeat (3) @(negedge clk);
    // R4: both ways hold the same tag, both dropped
    fillLine(1, ADDR_A);
    curReq = "R4";  runOp(5'd0, 5'd6, 0, ADDR_A, 0, 0, 1, 0, 1, 6'd0, 10'd982, 1);
    // R10: start held for two cycles gives one operation
    fillLine(0, ADDR_B);
    curReq = "R10"; runOp(5'd0, 5'd6, 0, ADDR_B, 0, 0, 1, 0, 1, 6'd0, 10'd982, 2);

    // R12: fill colliding with invalidate of the same line loses
    fillLine(1, ADDR_C);
    curReq = "R12";
    @(negedge clk);
    instr = mkWord(5'd0, 5'd1, 6'd0, 10'd982); raVal = 0; rbVal = ADDR_C;
    dataReloc = 0; userMode = 0; tlbHit = 1; zoneNoAccess = 0; start = 1;
    @(negedge clk); start = 0;
    fillEn = 1; fillWay = 1; fillSet = setOf(ADDR_C); fillTag = tagOf(ADDR_C);
    @(negedge clk); fillEn = 0;
    repeat (2) @(negedge clk);
    runOp(5'd0, 5'd1, 0, ADDR_C, 0, 0, 1, 0, 1, 6'd0, 10'd982, 1);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule